// File: doc/BRIEF.md
# Slave Frame Slot Exchange Engine

This block sits in the forward path of one slave on a daisy-chained field bus. Every frame byte that enters leaves again exactly one clock later. While the byte passes, the engine waits for the start-of-frame delimiter and reads the position byte that follows it. It sends that byte on increased by one, so each slave in the chain learns its own position without any addressing. The value it read selects one fixed-size slot in the payload. While that slot goes by, the engine keeps the incoming command bytes and puts its own response bytes on the wire in their place. It then writes a new CRC byte over the slot's check byte.

The engine is a six-state machine:
- IDLE leaves on a rising frame-valid. It goes to HUNT, or straight to COUNT if the first byte is already the delimiter.
- HUNT waits for the delimiter.
- COUNT handles the position byte. It goes to SEEK, or to SWAP when the slot begins at once.
- SEEK counts down to the slot.
- SWAP replaces the slot bytes.
- CHECK writes the CRC byte and returns to IDLE.

Frame-valid falling in any state other than IDLE aborts to IDLE. The command bytes are published only when the check byte that arrives with them is correct.

A node strapped as last in the chain turns the processed stream onto the backward output instead of the forward output.

Top module: `sx_slot_engine`

## Requirements
- R1: Every input byte and its valid bit appear on the active output one clock later. Bytes outside the position byte, the own slot and its check byte are unchanged.
- R2: The engine leaves IDLE only on a rising frame-valid and acts on the first byte equal to 0xD5 after that rise, whatever the number of bytes before it. A frame may begin with the delimiter.
- R3: The byte after the delimiter is sent on increased by one, modulo 256 (0xFF becomes 0x00).
- R4: With P the position byte that was read and M the slot size in data bytes, the own slot starts P·(M+1) bytes after the position byte.
- R5: The k-th data byte of the own slot (k = 0 first) is replaced by resp_data[8k+7:8k].
- R6: The incoming slot data bytes are stored with the same byte packing as resp_data. When the received check byte matches, cmd_data takes them and cmd_valid pulses for one cycle, in the same cycle that the new check byte is output. cmd_data changes at no other time.
- R7: The check byte written after the slot is CRC-8 with polynomial 0x07, initial value 0x00 and MSB first, taken over the M response bytes in slot order.
- R8: If the received check byte differs from the CRC-8 of the received slot data bytes, crc_error pulses in place of cmd_valid and cmd_data keeps its value.
- R9: If frame-valid falls before the check byte, the frame is dropped: no pulse, cmd_data unchanged, and the next frame is handled normally.
- R10: With last_node high, the stream goes out on bwd_valid/bwd_data and the forward outputs stay at zero. With last_node low, the reverse holds.
- R11: After the check byte, the rest of the frame passes unchanged, including bytes equal to 0xD5.
- R12: During reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Frame-valid of the incoming stream |
| in_data | input | 8 | Incoming frame byte |
| last_node | input | 1 | Selects the backward output for the processed stream |
| resp_data | input | 8·M | Response bytes for the own slot, byte k in bits 8k+7:8k |
| fwd_valid | output | 1 | Forward valid |
| fwd_data | output | 8 | Forward byte |
| bwd_valid | output | 1 | Backward valid (last node only) |
| bwd_data | output | 8 | Backward byte (last node only) |
| cmd_data | output | 8·M | Last accepted command bytes |
| cmd_valid | output | 1 | One-cycle pulse when cmd_data is updated |
| crc_error | output | 1 | One-cycle pulse when the received slot check byte is wrong |

## Verification
Frames are sent with different preamble lengths, including none, and with position values 0, 1, 2 and 255. The position values separate an off-by-one in the slot offset from the slot position itself, and 255 shows the wrap of the incremented position byte. The cases below each separate one fault:
- A bad check byte in the own slot, against one in another slot, shows whether the comparison is limited to the own slot.
- A frame cut off inside the own slot, followed by a clean frame, shows whether an abort leaks captured bytes or leaves the sequencer stuck.
- A 0xD5 data byte after the own slot, together with a run in last-node mode, covers re-triggering and output routing.

// File: rtl/sx_pkg.sv
package sx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HUNT,
        ST_COUNT,
        ST_SEEK,
        ST_SWAP,
        ST_CHECK
    } sx_state_e;

    // One byte step of CRC-8, polynomial x^8+x^2+x+1, MSB first
    function automatic logic [7:0] crc8_step(input logic [7:0] acc, input logic [7:0] b);
        logic [7:0] c;
        c = acc ^ b;
        for (int i = 0; i < 8; i++) begin
            c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/sx_seq.sv
module sx_seq
    import sx_pkg::*;
#(
    parameter int          M   = 4,
    parameter logic [7:0]  SFD = 8'hD5,
    localparam int         IDX_W = (M > 1) ? $clog2(M) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output sx_state_e        state_o,
    output logic [IDX_W-1:0] idx_o
);
    localparam int STRIDE = M + 1;
    localparam int WAIT_W = 8 + $clog2(M + 2);

    sx_state_e         state_q, state_d;
    logic              valid_q;
    logic [WAIT_W-1:0] wait_q;
    logic [IDX_W-1:0]  idx_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            valid_q <= 1'b0;
        end else begin
            state_q <= state_d;
            valid_q <= in_valid;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (state_q != ST_IDLE && !in_valid) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (in_valid && !valid_q)
                        state_d = (in_data == SFD) ? ST_COUNT : ST_HUNT;
                end
                ST_HUNT: begin
                    if (in_data == SFD) state_d = ST_COUNT;
                end
                ST_COUNT: begin
                    state_d = (in_data == 8'd0) ? ST_SWAP : ST_SEEK;
                end
                ST_SEEK: begin
                    if (wait_q == WAIT_W'(1)) state_d = ST_SWAP;
                end
                ST_SWAP: begin
                    if (idx_q == IDX_W'(M - 1)) state_d = ST_CHECK;
                end
                ST_CHECK: begin
                    state_d = ST_IDLE;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // slot distance and byte index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_q <= '0;
            idx_q  <= '0;
        end else if (in_valid) begin
            if (state_q == ST_COUNT) begin
                wait_q <= WAIT_W'(in_data) * WAIT_W'(STRIDE);
                idx_q  <= '0;
            end else if (state_q == ST_SEEK) begin
                wait_q <= wait_q - WAIT_W'(1);
            end else if (state_q == ST_SWAP) begin
                idx_q  <= idx_q + IDX_W'(1);
            end
        end
    end

    assign state_o = state_q;
    assign idx_o   = idx_q;

endmodule

// File: rtl/sx_crc.sv
module sx_crc
    import sx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       step,
    input  logic [7:0] tx_byte,
    input  logic [7:0] rx_byte,
    output logic [7:0] tx_crc,
    output logic [7:0] rx_crc
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_crc <= 8'h00;
            rx_crc <= 8'h00;
        end else if (clear) begin
            tx_crc <= 8'h00;
            rx_crc <= 8'h00;
        end else if (step) begin
            tx_crc <= crc8_step(tx_crc, tx_byte);
            rx_crc <= crc8_step(rx_crc, rx_byte);
        end
    end
endmodule

// File: rtl/sx_egress.sv
module sx_egress
    import sx_pkg::*;
#(
    parameter int  M = 4,
    localparam int IDX_W = (M > 1) ? $clog2(M) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  sx_state_e        state,
    input  logic [IDX_W-1:0] idx,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic [7:0]       resp_byte,
    input  logic [7:0]       tx_crc,
    input  logic             last_node,
    output logic             fwd_valid,
    output logic [7:0]       fwd_data,
    output logic             bwd_valid,
    output logic [7:0]       bwd_data,
    output logic [7:0]       tx_byte
);
    logic [7:0] sel;

    always_comb begin
        sel = in_data;
        if (in_valid) begin
            unique case (state)
                ST_COUNT: sel = in_data + 8'd1;
                ST_SWAP:  sel = resp_byte;
                ST_CHECK: sel = tx_crc;
                default:  sel = in_data;
            endcase
        end
    end

    assign tx_byte = resp_byte;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fwd_valid <= 1'b0;
            fwd_data  <= 8'h00;
            bwd_valid <= 1'b0;
            bwd_data  <= 8'h00;
        end else begin
            fwd_valid <= in_valid & ~last_node;
            fwd_data  <= last_node ? 8'h00 : sel;
            bwd_valid <= in_valid & last_node;
            bwd_data  <= last_node ? sel : 8'h00;
        end
    end

    logic unused_idx;
    assign unused_idx = ^idx;
endmodule

// File: rtl/sx_slot_engine.sv
module sx_slot_engine
    import sx_pkg::*;
#(
    parameter int         M   = 4,
    parameter logic [7:0] SFD = 8'hD5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [7:0]     in_data,
    input  logic           last_node,
    input  logic [M*8-1:0] resp_data,
    output logic           fwd_valid,
    output logic [7:0]     fwd_data,
    output logic           bwd_valid,
    output logic [7:0]     bwd_data,
    output logic [M*8-1:0] cmd_data,
    output logic           cmd_valid,
    output logic           crc_error
);
    localparam int IDX_W = (M > 1) ? $clog2(M) : 1;

    sx_state_e        state;
    logic [IDX_W-1:0] idx;
    logic [7:0]       tx_crc, rx_crc, tx_byte, resp_byte;
    logic [7:0]       resp_b [M];
    logic [M*8-1:0]   shadow;
    logic             in_slot;

    assign in_slot = (state == ST_SWAP) && in_valid;

    sx_seq #(.M(M), .SFD(SFD)) seq_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .state_o(state), .idx_o(idx)
    );

    // per-byte response select and command capture
    for (genvar k = 0; k < M; k++) begin : g_byte
        logic [7:0] cap_q;
        assign resp_b[k] = resp_data[k*8 +: 8];
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          cap_q <= 8'h00;
            else if (in_slot && idx == IDX_W'(k)) cap_q <= in_data;
        end
        assign shadow[k*8 +: 8] = cap_q;
    end

    assign resp_byte = resp_b[idx];

    sx_crc crc_i (
        .clk(clk), .rst_n(rst_n),
        .clear(state == ST_COUNT),
        .step(in_slot),
        .tx_byte(tx_byte), .rx_byte(in_data),
        .tx_crc(tx_crc), .rx_crc(rx_crc)
    );

    sx_egress #(.M(M)) egr_i (
        .clk(clk), .rst_n(rst_n), .state(state), .idx(idx),
        .in_valid(in_valid), .in_data(in_data), .resp_byte(resp_byte),
        .tx_crc(tx_crc), .last_node(last_node),
        .fwd_valid(fwd_valid), .fwd_data(fwd_data),
        .bwd_valid(bwd_valid), .bwd_data(bwd_data), .tx_byte(tx_byte)
    );

    // command publication on slot check
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_data  <= '0;
            cmd_valid <= 1'b0;
            crc_error <= 1'b0;
        end else begin
            cmd_valid <= 1'b0;
            crc_error <= 1'b0;
            if (state == ST_CHECK && in_valid) begin
                if (in_data == rx_crc) begin
                    cmd_data  <= shadow;
                    cmd_valid <= 1'b1;
                end else begin
                    crc_error <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/sx_slot_chk.sv
module sx_slot_chk #(
    parameter int M = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic           last_node,
    input logic           fwd_valid,
    input logic [7:0]     fwd_data,
    input logic           bwd_valid,
    input logic [M*8-1:0] cmd_data,
    input logic           cmd_valid,
    input logic           crc_error
);
    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_fwd_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (fwd_valid == ($past(in_valid) && !$past(last_node))));

    assert_bwd_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (bwd_valid == ($past(in_valid) && $past(last_node))));

    assert_one_path_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(fwd_valid && bwd_valid));

    assert_fwd_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(last_node)) |-> (fwd_data == 8'h00));

    assert_cmd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !cmd_valid) |-> $stable(cmd_data));

    assert_cmd_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    assert_flag_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && crc_error));
endmodule

bind sx_slot_engine sx_slot_chk #(.M(M)) chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .last_node(last_node),
    .fwd_valid(fwd_valid), .fwd_data(fwd_data), .bwd_valid(bwd_valid),
    .cmd_data(cmd_data), .cmd_valid(cmd_valid), .crc_error(crc_error)
);

// File: tb/sx_slot_engine_tb.sv
module sx_slot_engine_tb_top;
    localparam int M = 4;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           in_valid;
    logic [7:0]     in_data;
    logic           last_node;
    logic [M*8-1:0] resp_data;
    logic           fwd_valid, bwd_valid, cmd_valid, crc_error;
    logic [7:0]     fwd_data, bwd_data;
    logic [M*8-1:0] cmd_data;

    always #2 clk = ~clk;

    sx_slot_engine #(.M(M)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .last_node(last_node), .resp_data(resp_data),
        .fwd_valid(fwd_valid), .fwd_data(fwd_data),
        .bwd_valid(bwd_valid), .bwd_data(bwd_data),
        .cmd_data(cmd_data), .cmd_valid(cmd_valid), .crc_error(crc_error)
    );

    typedef struct {
        logic       v;
        logic [7:0] d;
        logic       cv;
        logic       ce;
        logic       last;
        string      tag;
    } exp_t;

    exp_t           q[$];
    int             checks = 0;
    int             fails  = 0;
    logic [M*8-1:0] exp_cmd = '0;

    function automatic logic [7:0] ref_crc(input logic [7:0] b[$]);
        logic [7:0] c = 8'h00;
        foreach (b[i]) begin
            c = c ^ b[i];
            for (int j = 0; j < 8; j++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
        end
        return c;
    endfunction

    task automatic push_cycle(input logic v, input logic [7:0] d, input exp_t e);
        @(negedge clk);
        in_valid = v;
        in_data  = d;
        q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.v = 0; e.d = 0; e.cv = 0; e.ce = 0; e.last = last_node; e.tag = "R1";
            push_cycle(1'b0, 8'h00, e);
        end
    endtask

    task automatic drain();
        while (q.size() != 0) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_cmd(input string tag);
        checks++;
        if (cmd_data !== exp_cmd) begin
            fails++;
            $display("FAIL %s cmd_data actual=%h expected=%h", tag, cmd_data, exp_cmd);
        end
    endtask

    // one frame: preamble, delimiter, position byte, nslots slots of M data + check
    task automatic send_frame(input int plen, input logic [7:0] ctr, input int nslots,
                              input logic [7:0] seed, input int bad_slot, input int cut,
                              input logic last, input logic [M*8-1:0] rsp);
        logic [7:0] fin[$];
        logic [7:0] own[$];
        logic [7:0] rb[$];
        logic [7:0] crc_rsp;
        int base, n;
        logic good;
        @(negedge clk);
        last_node = last;
        resp_data = rsp;
        in_valid  = 0;
        in_data   = 0;
        begin
            exp_t e0;
            e0.v = 0; e0.d = 0; e0.cv = 0; e0.ce = 0; e0.last = last; e0.tag = "R10";
            q.push_back(e0);
        end
        for (int i = 0; i < plen; i++) fin.push_back(8'h55);
        fin.push_back(8'hD5);
        fin.push_back(ctr);
        for (int s = 0; s < nslots; s++) begin
            logic [7:0] sb[$];
            for (int k = 0; k < M; k++) sb.push_back(8'(seed + s * 8 + k));
            foreach (sb[k]) fin.push_back(sb[k]);
            fin.push_back(ref_crc(sb) ^ ((s == bad_slot) ? 8'h5A : 8'h00));
        end
        base = plen + 2 + int'(ctr) * (M + 1);
        for (int k = 0; k < M; k++) begin
            rb.push_back(rsp[k*8 +: 8]);
            own.push_back(fin[base + k]);
        end
        crc_rsp = ref_crc(rb);
        good = (fin[base + M] == ref_crc(own));
        n = (cut < 0) ? fin.size() : cut;
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.v = 1; e.d = fin[i]; e.cv = 0; e.ce = 0; e.last = last; e.tag = "R1";
            if (i <= plen) e.tag = "R2";
            if (i == plen + 1) begin e.d = fin[i] + 8'd1; e.tag = "R3"; end
            else if (i >= base && i < base + M) begin e.d = rb[i - base]; e.tag = "R4,R5"; end
            else if (i == base + M) begin
                e.d = crc_rsp; e.tag = good ? "R6,R7" : "R7,R8"; e.cv = good; e.ce = !good;
            end else if (i > base + M) e.tag = "R11";
            if (last) e.tag = {"R10 ", e.tag};
            push_cycle(1'b1, fin[i], e);
        end
        idle(3);
        drain();
        if (n > base + M && good) begin
            for (int k = 0; k < M; k++) exp_cmd[k*8 +: 8] = own[k];
            chk_cmd("R6");
        end else if (n > base + M) chk_cmd("R8");
        else chk_cmd("R9");
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                logic ev_f, ev_b;
                logic [7:0] ed_f, ed_b;
                e = q.pop_front();
                ev_f = e.last ? 1'b0 : e.v;  ed_f = e.last ? 8'h00 : e.d;
                ev_b = e.last ? e.v : 1'b0;  ed_b = e.last ? e.d : 8'h00;
                checks++;
                if (fwd_valid !== ev_f || fwd_data !== ed_f || bwd_valid !== ev_b ||
                    bwd_data !== ed_b || cmd_valid !== e.cv || crc_error !== e.ce) begin
                    fails++;
                    $display("FAIL %s actual fwd=%b/%h bwd=%b/%h cv=%b ce=%b expected fwd=%b/%h bwd=%b/%h cv=%b ce=%b",
                             e.tag, fwd_valid, fwd_data, bwd_valid, bwd_data, cmd_valid, crc_error,
                             ev_f, ed_f, ev_b, ed_b, e.cv, e.ce);
                end
            end
        end
    end

    initial begin
        rst_n = 0; in_valid = 0; in_data = 0; last_node = 0; resp_data = '0;
        fork
            begin
                repeat (3) @(posedge clk);
                #1;
                checks++;
                if (fwd_valid !== 0 || fwd_data !== 0 || bwd_valid !== 0 || bwd_data !== 0 ||
                    cmd_data !== 0 || cmd_valid !== 0 || crc_error !== 0) begin
                    fails++;
                    $display("FAIL R12 reset outputs actual=%b%h%b%h%h%b%b expected all zero",
                             fwd_valid, fwd_data, bwd_valid, bwd_data, cmd_data, cmd_valid, crc_error);
                end
                @(negedge clk);
                rst_n = 1;
                idle(2);
                // R4 position 0, full preamble
                send_frame(7, 8'd0, 3, 8'h10, -1, -1, 1'b0, 32'hA1B2C3D4);
                // R4 position 2, short preamble
                send_frame(3, 8'd2, 4, 8'h20, -1, -1, 1'b0, 32'h11223344);
                // R2 delimiter on the very first valid byte
                send_frame(0, 8'd1, 2, 8'h30, -1, -1, 1'b0, 32'h0F1E2D3C);
                // R8 bad check byte in own slot
                send_frame(7, 8'd1, 3, 8'h40, 1, -1, 1'b0, 32'h55AA55AA);
                // R8 bad check byte in another slot has no effect on own slot
                send_frame(7, 8'd1, 3, 8'h48, 2, -1, 1'b0, 32'h01020304);
                // R9 frame cut inside own slot, then a clean frame
                send_frame(7, 8'd1, 3, 8'h60, -1, 7 + 2 + 5 + 2, 1'b0, 32'hDEADBEEF);
                send_frame(7, 8'd1, 3, 8'h70, -1, -1, 1'b0, 32'hCAFEF00D);
                // R11 a 0xD5 data byte after own slot
                send_frame(7, 8'd1, 3, 8'hC5, -1, -1, 1'b0, 32'h89ABCDEF);
                // R10 last-node loopback
                send_frame(7, 8'd1, 3, 8'h80, -1, -1, 1'b1, 32'h13579BDF);
                send_frame(5, 8'd0, 2, 8'h90, -1, -1, 1'b0, 32'h2468ACE0);
                // R3 position byte wraps 0xFF -> 0x00, R4 far slot
                send_frame(7, 8'd255, 256, 8'h05, -1, -1, 1'b0, 32'hFEDCBA98);
                idle(2);
                drain();
            end
            begin
                repeat (190000) @(posedge clk);
                fails++;
                $display("FAIL R1 watchdog expired actual=running expected=done");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule